// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block decides whether a frequency synthesizer is in lock. It samples the charge-pump activity signal once per crystal clock cycle and measures how long each activity pulse stays high. A pulse that lasts longer than one crystal period counts as over-width, and the loop is then taken to be out of lock. A separate strobe marks the end of each comparison (reference) period. The block counts how many periods in a row passed with no over-width pulse.

The lock flag is a register with asymmetric hysteresis. One over-width pulse clears it on the next crystal edge. Setting it again takes a full run of consecutive clean reference periods, eight by default. The block powers up unlocked.

The crystal clock and the strobe come from the surrounding synthesizer. With a 4 MHz crystal and a divide-by-64 reference, the flag clears within one 16 µs period of lock loss. It sets 8 to 9 periods (128 to 144 µs) after lock returns.

Top module: `pll_lock_judge`

## Requirements
- R1: While `rst_n` is low, `lock_flag` is 0 at once, without waiting for a clock edge. After release, the block needs a complete run of GOOD_RUN clean periods before the flag can set.
- R2: A pulse on `cp_active` that stays high for at most WIDE_CYC consecutive samples is not over-width. It leaves `lock_flag` unchanged.
- R3: Some sample may be the (WIDE_CYC+1)-th consecutive high sample of `cp_active` (with the default WIDE_CYC=1, the second high sample in a row). `lock_flag` is then 0 after that clock edge.
- R4: `lock_flag` rises only at the edge that samples `ref_tick`=1, and only when that sample closes the GOOD_RUN-th consecutive clean period (8 by default).
- R5: A reference period in which `cp_active` never goes high counts as a clean period.
- R6: An over-width pulse anywhere in a period makes that period unclean and restarts the count. The flag is then set by the GOOD_RUN-th clean period after the tick that closes the unclean one.
- R7: Several short pulses within one period, each followed by at least one low sample, leave the period clean.
- R8: Once set, `lock_flag` stays 1 for as long as no over-width pulse occurs, however many further ticks arrive.
- R9: An over-width pulse whose detecting sample coincides with `ref_tick`=1 makes the period being closed unclean.
- R10: Pulse width is measured across period boundaries. A pulse that is high on the tick sample and on the following sample is over-width, and it clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal | input | 1 | Crystal-rate clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe on the last crystal cycle of each reference period |
| cp_active | input | 1 | High while the charge pump is driving current |
| lock_flag | output | 1 | Registered lock indication, 1 = locked |

## Verification
On every cycle, the assertions check three things:
- an over-width event clears the flag and the clean-period count on the next edge;
- the flag only ever rises on a tick edge;
- the flag holds while no over-width event is seen and the first high sample of a pulse is never judged wide.

Some properties only the bench's scenarios can show:
- that exactly eight clean periods are needed, neither seven nor nine;
- that an unclean period costs one extra tick;
- that pulses spanning a tick are measured whole;
- that several short pulses leave a period clean;
- that reset mid-lock forces a full new run.

// File: rtl/lkd_pkg.sv
package lkd_pkg;

  // Saturating increment used by every counter in the block.
  function automatic int unsigned sat_inc(input int unsigned value, input int unsigned top);
    if (value >= top) return top;
    return value + 1;
  endfunction

  // A pulse is over-width once the high samples already counted reach the limit
  // while the pulse is still high.
  function automatic logic pulse_is_wide(input logic high_now, input int unsigned seen,
                                         input int unsigned limit);
    return high_now && (seen >= limit);
  endfunction

  // Width of a counter that must hold 0..top.
  function automatic int unsigned cnt_bits(input int unsigned top);
    return (top < 1) ? 1 : $clog2(top + 1);
  endfunction

endpackage

// File: rtl/lkd_width_meter.sv
module lkd_width_meter
  import lkd_pkg::*;
#(
  parameter int unsigned WIDE_CYC = 1
) (
  input  logic clk_xtal,
  input  logic rst_n,
  input  logic cp_active,
  output logic wide_evt
);
  localparam int unsigned CNT_W = cnt_bits(WIDE_CYC);

  logic [CNT_W-1:0] high_seen;

  // Restarts from zero whenever the pulse drops; saturates at the limit.
  always_ff @(posedge clk_xtal or negedge rst_n) begin
    if (!rst_n)
      high_seen <= '0;
    else if (cp_active)
      high_seen <= CNT_W'(sat_inc(int'(high_seen), WIDE_CYC));
    else
      high_seen <= '0;
  end

  assign wide_evt = pulse_is_wide(cp_active, int'(high_seen), WIDE_CYC);

  // R2
  first_high_not_wide_chk: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    (cp_active && !$past(cp_active)) |-> !wide_evt);

endmodule

// File: rtl/lkd_period_judge.sv
module lkd_period_judge
  import lkd_pkg::*;
#(
  parameter int unsigned GOOD_RUN = 8,
  localparam int unsigned GC_W = cnt_bits(GOOD_RUN)
) (
  input  logic            clk_xtal,
  input  logic            rst_n,
  input  logic            ref_tick,
  input  logic            wide_evt,
  output logic [GC_W-1:0] good_cnt,
  output logic            run_done
);
  logic bad_seen;
  logic period_clean;

  assign period_clean = !bad_seen && !wide_evt;

  always_ff @(posedge clk_xtal or negedge rst_n) begin
    if (!rst_n) begin
      bad_seen <= 1'b0;
      good_cnt <= '0;
    end else if (ref_tick) begin
      bad_seen <= 1'b0;
      if (period_clean)
        good_cnt <= GC_W'(sat_inc(int'(good_cnt), GOOD_RUN));
      else
        good_cnt <= '0;
    end else if (wide_evt) begin
      bad_seen <= 1'b1;
      good_cnt <= '0;
    end
  end

  assign run_done = ref_tick && period_clean && (int'(good_cnt) + 1 >= GOOD_RUN);

  // R6
  count_restart_chk: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    wide_evt |=> (good_cnt == '0));

endmodule

// File: rtl/lkd_flag_reg.sv
module lkd_flag_reg (
  input  logic clk_xtal,
  input  logic rst_n,
  input  logic wide_evt,
  input  logic run_done,
  output logic lock_q
);
  always_ff @(posedge clk_xtal or negedge rst_n) begin
    if (!rst_n)
      lock_q <= 1'b0;
    else if (wide_evt)
      lock_q <= 1'b0;
    else if (run_done)
      lock_q <= 1'b1;
  end

  // R8
  lock_hold_chk: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    (lock_q && !wide_evt) |=> lock_q);

endmodule

// File: rtl/pll_lock_judge.sv
module pll_lock_judge
  import lkd_pkg::*;
#(
  parameter int unsigned WIDE_CYC = 1,
  parameter int unsigned GOOD_RUN = 8
) (
  input  logic clk_xtal,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic cp_active,
  output logic lock_flag
);
  localparam int unsigned GC_W = cnt_bits(GOOD_RUN);

  logic            wide_evt;
  logic            run_done;
  logic [GC_W-1:0] good_cnt;

  lkd_width_meter #(.WIDE_CYC(WIDE_CYC)) i_meter (
    .clk_xtal (clk_xtal),
    .rst_n    (rst_n),
    .cp_active(cp_active),
    .wide_evt (wide_evt)
  );

  lkd_period_judge #(.GOOD_RUN(GOOD_RUN)) i_judge (
    .clk_xtal(clk_xtal),
    .rst_n   (rst_n),
    .ref_tick(ref_tick),
    .wide_evt(wide_evt),
    .good_cnt(good_cnt),
    .run_done(run_done)
  );

  lkd_flag_reg i_flag (
    .clk_xtal(clk_xtal),
    .rst_n   (rst_n),
    .wide_evt(wide_evt),
    .run_done(run_done),
    .lock_q  (lock_flag)
  );

  // R3
  clear_on_wide_chk: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    wide_evt |=> !lock_flag);

  // R4
  rise_on_tick_chk: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    $rose(lock_flag) |-> $past(ref_tick));

  // R4
  rise_after_full_run_chk: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    $rose(lock_flag) |-> (int'(good_cnt) >= GOOD_RUN));

endmodule

// File: tb/test_pll_lock_judge.sv
`timescale 1ns/1ps
module test_pll_lock_judge;
  localparam int CLK_PERIOD = 250;
  localparam int NVEC = 27;

  // Each entry: {16-cycle cp_active pattern (bit i = cycle i, tick on cycle 15), expected lock after tick}
  localparam logic [16:0] VEC [NVEC] = '{
    {16'h0008, 1'b0}, {16'h0008, 1'b0}, {16'h0008, 1'b0}, {16'h0008, 1'b0},
    {16'h0008, 1'b0}, {16'h0008, 1'b0}, {16'h0008, 1'b0}, {16'h0000, 1'b1},
    {16'h0008, 1'b1}, {16'h0018, 1'b0}, {16'h0008, 1'b0}, {16'h0008, 1'b0},
    {16'h0008, 1'b0}, {16'h0008, 1'b0}, {16'h0008, 1'b0}, {16'h0008, 1'b0},
    {16'h0008, 1'b0}, {16'h0000, 1'b1}, {16'h00F8, 1'b0}, {16'h0000, 1'b0},
    {16'h0000, 1'b0}, {16'h0000, 1'b0}, {16'h0000, 1'b0}, {16'h0000, 1'b0},
    {16'h0000, 1'b0}, {16'h0000, 1'b0}, {16'h0000, 1'b1}
  };

  logic clk_xtal = 1'b0;
  logic rst_n = 1'b0;
  logic ref_tick = 1'b0;
  logic cp_active = 1'b0;
  logic lock_flag;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_xtal = ~clk_xtal;

  pll_lock_judge i_pll_lock_judge (
    .clk_xtal (clk_xtal),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .cp_active(cp_active),
    .lock_flag(lock_flag)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Drive one crystal cycle from a negedge; return at the next negedge.
  task automatic cyc(input logic t, input logic p);
    ref_tick = t;
    cp_active = p;
    @(negedge clk_xtal);
  endtask

  task automatic run_pattern(input logic [15:0] pat);
    for (int i = 0; i < 16; i++) cyc(i == 15, pat[i]);
    ref_tick = 1'b0;
    cp_active = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_xtal);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk_xtal);
    chk("R1 flag low in reset", lock_flag, 1'b0);
    repeat (2) @(negedge clk_xtal);
    rst_n = 1'b1;
    @(negedge clk_xtal);
    chk("R1 flag low after release", lock_flag, 1'b0);

    // Table walk: R2 R4 R5 R6 R8
    for (int v = 0; v < NVEC; v++) begin
      run_pattern(VEC[v][16:1]);
      chk($sformatf("R4/R6 table entry %0d", v), lock_flag, VEC[v][0]);
    end

    // R2 / R3: mid-period clear timing while locked
    cyc(0, 0); cyc(0, 0);
    cyc(0, 1);
    chk("R2 one high sample keeps lock", lock_flag, 1'b1);
    cyc(0, 1);
    chk("R3 second high sample clears", lock_flag, 1'b0);
    for (int i = 0; i < 10; i++) cyc(0, 0);
    cyc(1, 0);
    for (int k = 0; k < 7; k++) run_pattern(16'h0000);
    chk("R6 seven clean after unclean", lock_flag, 1'b0);
    run_pattern(16'h0000);
    chk("R6 eighth clean sets", lock_flag, 1'b1);

    // R9: wide detected on the tick sample
    run_pattern(16'hC000);
    chk("R9 wide on tick clears", lock_flag, 1'b0);
    for (int k = 0; k < 7; k++) run_pattern(16'h0000);
    chk("R9 tick period counted unclean", lock_flag, 1'b0);
    run_pattern(16'h0000);
    chk("R9 relock after eight", lock_flag, 1'b1);

    // R7: several short pulses
    run_pattern(16'h5555);
    chk("R7 short pulses keep lock", lock_flag, 1'b1);

    // R10: pulse spanning a tick
    run_pattern(16'h8000);
    chk("R10 single high on tick is clean", lock_flag, 1'b1);
    cyc(0, 1);
    chk("R10 pulse continued across tick clears", lock_flag, 1'b0);
    for (int i = 1; i < 15; i++) cyc(0, 0);
    cyc(1, 0);

    // R1: reset mid-lock, then a full run is required; R7 from unlocked
    for (int k = 0; k < 8; k++) run_pattern(16'h0000);
    chk("R8 relocked before reset", lock_flag, 1'b1);
    #(CLK_PERIOD/4) rst_n = 1'b0;
    #1;
    chk("R1 async reset clears flag", lock_flag, 1'b0);
    @(negedge clk_xtal);
    rst_n = 1'b1;
    for (int k = 0; k < 7; k++) run_pattern(16'h2222);
    chk("R7 seven periods of short pulses", lock_flag, 1'b0);
    run_pattern(16'h2222);
    chk("R7 eighth period of short pulses sets", lock_flag, 1'b1);

    // R10: long pulse across a whole period
    run_pattern(16'hFFFF);
    chk("R10 long pulse clears", lock_flag, 1'b0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule